// File: doc/BRIEF.md
# Coalescing Write Buffer

This block sits between a write-through cache and the next memory level. Every store that the cache writes through lands here as a single 32-bit word write. The buffer keeps pending writes in a small ring of entries. Each entry covers one aligned block of four words and has one valid bit per word. A store into a block that already has an entry is folded into that entry instead of taking a new slot. A burst of stores to neighbouring words therefore leaves as a single masked block write.

Read misses from the cache are checked against the buffer before memory sees them. A miss whose word is pending is answered straight from the buffer. A miss that touches no buffered block goes to memory ahead of any pending drain. A miss that hits a buffered block in a word that is not pending is held until that block has been written out. This way, a load can never see memory data older than a store that was already accepted.

One memory port carries both the block writes that drain the buffer and the word reads that bypass it. The `mem_we` signal tells the two apart.

Top module: `wbuf_merge`

## Requirements
- R1: After reset the buffer is empty: `mem_valid` is low, `wr_ready` is high and `rd_fwd` is low.
- R2: A write is merged when its block number matches a buffered entry. The block number is the byte address without its low 4 bits, for the default sizes. A merged write sets that word's valid bit and does not take a new entry. Four writes to 0x100, 0x104, 0x108 and 0x10C leave the buffer as one request with mask 4'b1111.
- R3: A write to a word that is already valid in its entry replaces that word's data, and the valid mask stays the same.
- R4: Entries drain oldest first. A drain presents `mem_valid`=1 and `mem_we`=1, with `mem_addr` set to the block base. Word i is on `mem_wdata[32*i+31:32*i]` and its valid bit is on `mem_wmask[i]`. The entry is released in the cycle where `mem_ready` is high.
- R5: With all four entries in use, a write that matches no entry sees `wr_ready` low. A write that merges into an existing entry is still accepted.
- R6: A read whose word is valid in the buffer raises `rd_fwd` and `rd_ready` in the same cycle, with the newest data on `rd_fwd_data`. That cycle issues no memory read.
- R7: A read whose block matches no entry is sent to memory ahead of draining, with `mem_we`=0 and `mem_addr`=`rd_addr`. It is accepted (`rd_ready` high) in the cycle where `mem_ready` is high.
- R8: A read whose block is buffered but whose word is not valid keeps `rd_ready` low. Draining continues meanwhile, and the read goes to memory once the block has left the buffer.
- R9: A write into the head entry during the cycle in which that entry is drained sees `wr_ready` low. It is taken in a later cycle as a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store request from the cache |
| wr_ready | output | 1 | Store accepted this cycle when high together with wr_valid |
| wr_addr | input | AW | Byte address of the stored word |
| wr_data | input | DW | Stored word |
| rd_valid | input | 1 | Read-miss request |
| rd_ready | output | 1 | Read miss accepted (forwarded or issued to memory) |
| rd_addr | input | AW | Byte address of the missed word |
| rd_fwd | output | 1 | Read is answered from the buffer this cycle |
| rd_fwd_data | output | DW | Forwarded word, zero when rd_fwd is low |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory takes the request this cycle |
| mem_we | output | 1 | 1 = block write from a drain, 0 = word read |
| mem_addr | output | AW | Block base for writes, read address for reads |
| mem_wdata | output | WORDS*DW | Block data, word i at slice i |
| mem_wmask | output | WORDS | Per-word write enable of the drained entry |

## Verification
A merge that goes into the wrong slot or loses a valid bit shows up at the memory port. The faulty drain then carries a wrong mask or wrong data, or there are more drains than stores warrant. This becomes visible as soon as the memory side accepts the entry. A broken block match shows within the same cycle. It either forwards a word that was never written, or it lets a read pass to memory while a newer store to that block is still queued. A broken occupancy count appears as `wr_ready` held at the wrong level as soon as the fifth distinct block arrives. A broken head pointer appears at the first drain after a wrap, which has the wrong address.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  // who owns the memory port in a given cycle
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_DRAIN = 2'd1,
    ARB_RDMEM = 2'd2
  } arb_e;

  // ring pointer step
  function automatic int unsigned ring_step(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int DEPTH = 4,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int BW    = 28,
  localparam int IW   = $clog2(WORDS),
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_fire,
  input  logic [DEPTH-1:0]                    wr_hit_vec,
  input  logic [BW-1:0]                       wr_blk,
  input  logic [IW-1:0]                       wr_word,
  input  logic [DW-1:0]                       wr_data,
  input  logic                                pop,
  output logic [DEPTH-1:0]                    used,
  output logic [DEPTH-1:0][BW-1:0]            blk,
  output logic [DEPTH-1:0][WORDS-1:0]         mask,
  output logic [DEPTH-1:0][WORDS-1:0][DW-1:0] data,
  output logic [PW-1:0]                       head,
  output logic [CW-1:0]                       count
);
  import wbuf_pkg::*;

  logic [PW-1:0] tail;
  logic [PW-1:0] hit_idx;
  logic          merge;
  logic          alloc;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (wr_hit_vec[i]) hit_idx = PW'(i);
  end

  assign merge = wr_fire && (|wr_hit_vec);
  assign alloc = wr_fire && !(|wr_hit_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used  <= '0;
      mask  <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (pop) begin
        used[head] <= 1'b0;
        mask[head] <= '0;
        head       <= PW'(ring_step(int'(head), DEPTH));
      end
      if (merge) begin
        mask[hit_idx][wr_word] <= 1'b1;
        data[hit_idx][wr_word] <= wr_data;
      end
      if (alloc) begin
        used[tail]          <= 1'b1;
        blk[tail]           <= wr_blk;
        mask[tail]          <= WORDS'(1) << wr_word;
        data[tail][wr_word] <= wr_data;
        tail                <= PW'(ring_step(int'(tail), DEPTH));
      end
      count <= count + CW'(alloc) - CW'(pop);
    end
  end

endmodule

// File: rtl/wbuf_lookup.sv
module wbuf_lookup #(
  parameter int DEPTH = 4,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int BW    = 28,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic [DEPTH-1:0]                    used,
  input  logic [DEPTH-1:0][BW-1:0]            blk,
  input  logic [DEPTH-1:0][WORDS-1:0]         mask,
  input  logic [DEPTH-1:0][WORDS-1:0][DW-1:0] data,
  input  logic [BW-1:0]                       q_blk,
  input  logic [IW-1:0]                       q_word,
  output logic [DEPTH-1:0]                    hit_vec,
  output logic                                word_hit,
  output logic [DW-1:0]                       word_data
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = used[i] && (blk[i] == q_blk);
  end

  // at most one entry per block exists, so an OR-merge is exact
  always_comb begin
    word_hit  = 1'b0;
    word_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i] && mask[i][q_word]) begin
        word_hit  = 1'b1;
        word_data = word_data | data[i][q_word];
      end
    end
  end

endmodule

// File: rtl/wbuf_arbiter.sv
module wbuf_arbiter
  import wbuf_pkg::*;
(
  input  logic rd_valid,
  input  logic rd_blk_any,
  input  logic rd_word_hit,
  input  logic nonempty,
  input  logic full,
  input  logic mem_ready,
  input  logic wr_valid,
  input  logic wr_blk_any,
  input  logic wr_hits_head,
  output arb_e arb,
  output logic mem_valid,
  output logic mem_we,
  output logic pop,
  output logic rd_fwd,
  output logic rd_ready,
  output logic wr_ready,
  output logic wr_fire
);

  always_comb begin
    if (rd_valid && !rd_blk_any) arb = ARB_RDMEM;
    else if (nonempty)           arb = ARB_DRAIN;
    else                         arb = ARB_IDLE;
  end

  assign mem_valid = (arb != ARB_IDLE);
  assign mem_we    = (arb == ARB_DRAIN);
  assign pop       = (arb == ARB_DRAIN) && mem_ready;
  assign rd_fwd    = rd_valid && rd_word_hit;
  assign rd_ready  = rd_fwd || ((arb == ARB_RDMEM) && mem_ready);
  assign wr_ready  = wr_blk_any ? !(wr_hits_head && pop) : !full;
  assign wr_fire   = wr_valid && wr_ready;

endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 4,
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic                rd_valid,
  output logic                rd_ready,
  input  logic [AW-1:0]       rd_addr,
  output logic                rd_fwd,
  output logic [DW-1:0]       rd_fwd_data,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [WORDS*DW-1:0] mem_wdata,
  output logic [WORDS-1:0]    mem_wmask
);
  import wbuf_pkg::*;

  localparam int OFF_SH = $clog2(DW / 8);
  localparam int IW     = $clog2(WORDS);
  localparam int BLK_SH = OFF_SH + IW;
  localparam int BW     = AW - BLK_SH;
  localparam int PW     = $clog2(DEPTH);
  localparam int CW     = $clog2(DEPTH + 1);

  function automatic logic [BW-1:0] blk_of(input logic [AW-1:0] a);
    return a[AW-1:BLK_SH];
  endfunction

  function automatic logic [IW-1:0] word_of(input logic [AW-1:0] a);
    return a[BLK_SH-1:OFF_SH];
  endfunction

  function automatic logic [AW-1:0] blk_base(input logic [BW-1:0] b);
    return {b, {BLK_SH{1'b0}}};
  endfunction

  // storage view
  logic [DEPTH-1:0]                    used;
  logic [DEPTH-1:0][BW-1:0]            blk;
  logic [DEPTH-1:0][WORDS-1:0]         mask;
  logic [DEPTH-1:0][WORDS-1:0][DW-1:0] data;
  logic [PW-1:0]                       head;
  logic [CW-1:0]                       count;

  // named events for the checker
  logic [DEPTH-1:0] wr_hit_vec;
  logic [DEPTH-1:0] rd_hit_vec;
  logic             wr_blk_any;
  logic             rd_blk_any;
  logic             wr_word_hit_unused;
  logic [DW-1:0]    wr_word_data_unused;
  logic             rd_word_hit;
  logic [DW-1:0]    rd_word_data;
  logic             wr_hits_head;
  logic             full;
  logic             nonempty;
  logic             pop;
  logic             wr_fire;
  arb_e             arb;
  logic             unused_off;

  assign unused_off = ^{wr_addr[OFF_SH-1:0], wr_word_hit_unused, wr_word_data_unused};

  wbuf_store #(.DEPTH(DEPTH), .WORDS(WORDS), .DW(DW), .BW(BW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_hit_vec (wr_hit_vec),
    .wr_blk     (blk_of(wr_addr)),
    .wr_word    (word_of(wr_addr)),
    .wr_data    (wr_data),
    .pop        (pop),
    .used       (used),
    .blk        (blk),
    .mask       (mask),
    .data       (data),
    .head       (head),
    .count      (count)
  );

  wbuf_lookup #(.DEPTH(DEPTH), .WORDS(WORDS), .DW(DW), .BW(BW)) u_wr_look (
    .used      (used),
    .blk       (blk),
    .mask      (mask),
    .data      (data),
    .q_blk     (blk_of(wr_addr)),
    .q_word    (word_of(wr_addr)),
    .hit_vec   (wr_hit_vec),
    .word_hit  (wr_word_hit_unused),
    .word_data (wr_word_data_unused)
  );

  wbuf_lookup #(.DEPTH(DEPTH), .WORDS(WORDS), .DW(DW), .BW(BW)) u_rd_look (
    .used      (used),
    .blk       (blk),
    .mask      (mask),
    .data      (data),
    .q_blk     (blk_of(rd_addr)),
    .q_word    (word_of(rd_addr)),
    .hit_vec   (rd_hit_vec),
    .word_hit  (rd_word_hit),
    .word_data (rd_word_data)
  );

  assign wr_blk_any   = |wr_hit_vec;
  assign rd_blk_any   = |rd_hit_vec;
  assign wr_hits_head = wr_hit_vec[head];
  assign full         = (count == CW'(DEPTH));
  assign nonempty     = (count != '0);

  wbuf_arbiter u_arb (
    .rd_valid     (rd_valid),
    .rd_blk_any   (rd_blk_any),
    .rd_word_hit  (rd_word_hit),
    .nonempty     (nonempty),
    .full         (full),
    .mem_ready    (mem_ready),
    .wr_valid     (wr_valid),
    .wr_blk_any   (wr_blk_any),
    .wr_hits_head (wr_hits_head),
    .arb          (arb),
    .mem_valid    (mem_valid),
    .mem_we       (mem_we),
    .pop          (pop),
    .rd_fwd       (rd_fwd),
    .rd_ready     (rd_ready),
    .wr_ready     (wr_ready),
    .wr_fire      (wr_fire)
  );

  assign rd_fwd_data = rd_fwd ? rd_word_data : '0;
  assign mem_addr    = (arb == ARB_DRAIN) ? blk_base(blk[head]) : rd_addr;
  assign mem_wdata   = (arb == ARB_DRAIN) ? data[head] : '0;
  assign mem_wmask   = (arb == ARB_DRAIN) ? mask[head] : '0;

endmodule

// File: rtl/wbuf_merge_chk.sv
module wbuf_merge_chk #(
  parameter int WORDS = 4,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             wr_fire,
  input logic             wr_blk_any,
  input logic             wr_hits_head,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic             rd_blk_any,
  input logic             rd_fwd,
  input logic             mem_valid,
  input logic             mem_we,
  input logic [WORDS-1:0] mem_wmask,
  input logic             pop,
  input logic             full,
  input logic [CW-1:0]    count
);

  p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> (count == '0));

  p_merge_keeps_slots_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_blk_any) |=> (count == $past(count) - CW'($past(pop))));

  p_alloc_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_blk_any && !pop) |=> (count == $past(count) + CW'(1)));

  p_drain_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_wmask != '0));

  p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !wr_blk_any) |-> !wr_ready);

  p_fwd_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fwd |-> (rd_ready && !(mem_valid && !mem_we)));

  p_read_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_blk_any) |-> (mem_valid && !mem_we));

  p_partial_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_blk_any && !rd_fwd) |-> !rd_ready);

  p_head_pop_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_hits_head && pop) |-> !wr_ready);

endmodule

bind wbuf_merge wbuf_merge_chk #(.WORDS(WORDS), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_fire      (wr_fire),
  .wr_blk_any   (wr_blk_any),
  .wr_hits_head (wr_hits_head),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .rd_blk_any   (rd_blk_any),
  .rd_fwd       (rd_fwd),
  .mem_valid    (mem_valid),
  .mem_we       (mem_we),
  .mem_wmask    (mem_wmask),
  .pop          (pop),
  .full         (full),
  .count        (count)
);

// File: tb/wbuf_merge_test.sv
module wbuf_merge_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_valid;
  logic         wr_ready;
  logic [31:0]  wr_addr;
  logic [31:0]  wr_data;
  logic         rd_valid;
  logic         rd_ready;
  logic [31:0]  rd_addr;
  logic         rd_fwd;
  logic [31:0]  rd_fwd_data;
  logic         mem_valid;
  logic         mem_ready;
  logic         mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [3:0]   mem_wmask;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [31:0]  addr;
    logic [3:0]   mask;
    logic [127:0] data;
  } drain_t;

  drain_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wbuf_merge uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_fwd(rd_fwd), .rd_fwd_data(rd_fwd_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_drain(input logic [31:0] a, input logic [3:0] m,
                              input logic [31:0] d0, input logic [31:0] d1,
                              input logic [31:0] d2, input logic [31:0] d3);
    drain_t e;
    e.addr = a; e.mask = m; e.data = {d3, d2, d1, d0};
    exp_q.push_back(e);
  endtask

  // scoreboard monitor: memory-side writes accepted this cycle
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_we && mem_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected drain: actual addr %0h mask %0h expected none", mem_addr, mem_wmask);
      end else begin
        drain_t e;
        logic [127:0] keep;
        e = exp_q.pop_front();
        for (int w = 0; w < 4; w++) keep[w*32 +: 32] = {32{e.mask[w]}};
        check("R4", {96'b0, mem_addr}, {96'b0, e.addr}, "drain address");
        check("R4", {124'b0, mem_wmask}, {124'b0, e.mask}, "drain mask");
        check("R2/R3", mem_wdata & keep, e.data & keep, "drain data");
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    int n = 0;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    while (!wr_ready && n < 100) begin
      step(); @(negedge clk); n++;
    end
    if (n >= 100) begin
      checks++; errors++;
      $display("FAIL R5 write %0h never accepted: actual ready 0 expected 1", a);
    end
    step();
    wr_valid = 1'b0;
  endtask

  task automatic wait_empty();
    int n = 0;
    @(negedge clk);
    while (mem_valid && n < 100) begin
      step(); @(negedge clk); n++;
    end
    check("R4", {127'b0, mem_valid}, 128'd0, "buffer drained");
    check("R4", 128'(exp_q.size()), 128'd0, "all expected drains seen");
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    rd_valid = 1'b0; rd_addr = '0; mem_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", {127'b0, mem_valid}, 128'd0, "mem_valid after reset");
    check("R1", {127'b0, wr_ready}, 128'd1, "wr_ready after reset");
    check("R1", {127'b0, rd_fwd}, 128'd0, "rd_fwd after reset");
    step();

    // R2 + R3: merging and overwrite, memory stalled
    do_write(32'h100, 32'hA000_0000);
    do_write(32'h104, 32'hA000_0001);
    do_write(32'h108, 32'hA000_0002);
    do_write(32'h10C, 32'hA000_0003);
    do_write(32'h104, 32'hB000_0001);
    do_write(32'h200, 32'hC000_0000);
    do_write(32'h20C, 32'hC000_0003);
    @(negedge clk);
    check("R2", {96'b0, mem_addr}, 128'h100, "head block address");
    check("R2", {124'b0, mem_wmask}, 128'hF, "merged mask");
    check("R3", {96'b0, mem_wdata[63:32]}, 128'hB000_0001, "overwritten word");
    expect_drain(32'h100, 4'hF, 32'hA000_0000, 32'hB000_0001, 32'hA000_0002, 32'hA000_0003);
    expect_drain(32'h200, 4'h9, 32'hC000_0000, 32'h0, 32'h0, 32'hC000_0003);

    // R6: forward a pending word
    step();
    rd_valid = 1'b1; rd_addr = 32'h108;
    @(negedge clk);
    check("R6", {127'b0, rd_fwd}, 128'd1, "forward flag");
    check("R6", {96'b0, rd_fwd_data}, 128'hA000_0002, "forward data");
    check("R6", {127'b0, rd_ready}, 128'd1, "forward ready");
    check("R6", {127'b0, mem_we}, 128'd1, "no memory read on forward");

    // R7: unmatched read takes the memory port
    step();
    rd_addr = 32'h400;
    @(negedge clk);
    check("R7", {126'b0, mem_valid, mem_we}, 128'b10, "read issued over drain");
    check("R7", {96'b0, mem_addr}, 128'h400, "read address");
    check("R7", {127'b0, rd_ready}, 128'd0, "read waits for memory");

    // R8: partial block match waits until the block drains
    step();
    rd_addr = 32'h204;
    @(negedge clk);
    check("R8", {127'b0, rd_ready}, 128'd0, "partial match held");
    check("R8", {96'b0, mem_addr}, 128'h100, "drain continues");
    step();
    mem_ready = 1'b1;
    begin
      int n = 0;
      @(negedge clk);
      while (!rd_ready && n < 20) begin
        step(); @(negedge clk); n++;
      end
      check("R8", 128'(n), 128'd2, "cycles until partial read proceeds");
      check("R8", {127'b0, mem_we}, 128'd0, "read goes to memory after drain");
      check("R8", {96'b0, mem_addr}, 128'h204, "read address after drain");
    end
    step();
    rd_valid = 1'b0;
    wait_empty();

    // R5: full buffer stalls a new block, merge still accepted
    mem_ready = 1'b0;
    do_write(32'h1000, 32'h1);
    do_write(32'h2000, 32'h2);
    do_write(32'h3000, 32'h3);
    do_write(32'h4000, 32'h4);
    wr_valid = 1'b1; wr_addr = 32'h5000; wr_data = 32'h5;
    @(negedge clk);
    check("R5", {127'b0, wr_ready}, 128'd0, "full stalls new block");
    step();
    wr_addr = 32'h2004; wr_data = 32'h22;
    @(negedge clk);
    check("R5", {127'b0, wr_ready}, 128'd1, "merge accepted while full");
    step();
    wr_valid = 1'b0;
    expect_drain(32'h1000, 4'h1, 32'h1, 0, 0, 0);
    expect_drain(32'h2000, 4'h3, 32'h2, 32'h22, 0, 0);
    expect_drain(32'h3000, 4'h1, 32'h3, 0, 0, 0);
    expect_drain(32'h4000, 4'h1, 32'h4, 0, 0, 0);
    mem_ready = 1'b1;
    wait_empty();

    // R9: write into the head while it drains
    mem_ready = 1'b0;
    do_write(32'h300, 32'hD0);
    expect_drain(32'h300, 4'h1, 32'hD0, 0, 0, 0);
    expect_drain(32'h300, 4'h2, 0, 32'hD1, 0, 0);
    mem_ready = 1'b1; wr_valid = 1'b1; wr_addr = 32'h304; wr_data = 32'hD1;
    @(negedge clk);
    check("R9", {127'b0, wr_ready}, 128'd0, "head write stalled during drain");
    step();
    do_write(32'h304, 32'hD1);
    wait_empty();

    // R6/R7: store 512, load 1024 (same line in the cache), load 512
    mem_ready = 1'b0;
    do_write(32'd512, 32'hE5);
    expect_drain(32'd512, 4'h1, 32'hE5, 0, 0, 0);
    rd_valid = 1'b1; rd_addr = 32'd1024;
    @(negedge clk);
    check("R7", {126'b0, mem_valid, mem_we}, 128'b10, "load 1024 goes first");
    step();
    mem_ready = 1'b1;
    @(negedge clk);
    check("R7", {127'b0, rd_ready}, 128'd1, "load 1024 accepted");
    check("R7", {127'b0, mem_we}, 128'd0, "drain held during read");
    step();
    mem_ready = 1'b0; rd_addr = 32'd512;
    @(negedge clk);
    check("R6", {127'b0, rd_fwd}, 128'd1, "load 512 forwarded");
    check("R6", {96'b0, rd_fwd_data}, 128'hE5, "load 512 sees newest store");
    step();
    rd_valid = 1'b0; mem_ready = 1'b1;
    wait_empty();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule